// File: doc/BRIEF.md
# Control Endpoint Status Register Logic

This block holds the command and status state of the default control endpoint in a USB device controller. Firmware reaches it through a byte-wide register port with a 2-bit address. The transaction engine reaches it through single-cycle event strobes and a few level outputs. Firmware loads commands such as "packet loaded", "send a stall" and "last packet of the transfer", and acknowledges received packets and aborted transfers. The engine reports packets received, packets sent, stalls sent, aborted control transfers and completed status stages.

The block keeps the flags and auto-clears the one-shot command bits. It requests a FIFO flush when a control transfer is cut short. It raises a one-cycle endpoint interrupt for each engine event while the enable input is high. The same port also reads back an endpoint index register and the current 11-bit frame number.

Address map: 0 = control/status byte, 1 = endpoint index, 2 = frame number bits 7:0, 3 = frame number bits 10:8. Control/status bits: 7 clear-abort (command), 6 clear-received (command), 5 stall command, 4 abort flag, 3 last-packet flag, 2 stall-sent flag, 1 transmit-ready flag, 0 received flag.

Top module: `ctl_ep_csr`

## Requirements
- R1: After reset, every control/status bit reads 0, the index reads 0, and stall_req_o, tx_ready_o, data_end_o, fifo_flush_o and ep0_irq_o are low.
- R2: A write of 1 to bit 7 clears the abort flag (bit 4). A write of 1 to bit 6 clears the received flag (bit 0). Bits 7 and 6 always read 0.
- R3: setup_abort_i sets the abort flag (bit 4) at the next edge, and fifo_flush_o pulses high for exactly that one cycle. Firmware writes to bit 4 have no effect.
- R4: A write of 1 to bit 5 drives stall_req_o high for the one cycle after the write. Bit 5 reads 1 in that cycle and 0 afterwards.
- R5: stall_sent_i sets the stall-sent flag (bit 2). A write with bit 2 = 0 clears it. A write with bit 2 = 1 leaves it unchanged. No engine event clears it.
- R6: A write of 1 to bit 1 sets the transmit-ready flag, which also drives tx_ready_o. A write of 0 to bit 1 has no effect. tx_pkt_done_i clears the flag.
- R7: rx_pkt_done_i sets the received flag (bit 0). Firmware writes to bit 0 have no effect.
- R8: A write of 1 to bit 3 sets the last-packet flag, which also drives data_end_o. status_stage_done_i clears it. If the write and status_stage_done_i fall in the same cycle, the flag is set.
- R9: When an engine event sets bit 4, bit 0 or bit 2 in the same cycle as a firmware write that would clear it, the flag ends up set.
- R10: In the cycle after any of rx_pkt_done_i, tx_pkt_done_i, stall_sent_i or setup_abort_i, ep0_irq_o is high for one cycle if irq_en_i was high with the event. It stays low otherwise. Several events in one cycle give one pulse.
- R11: The index register (address 1) takes write data bits 3:0 only when their value is 5 or less. Other writes leave it unchanged. Bits 7:4 read 0, and ep_index_o shows the held value.
- R12: Address 2 reads frame_num_i[7:0]. Address 3 reads frame_num_i[10:8] in bits 2:0 with bits 7:3 reading 0. Writes to both addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Firmware write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| ep_index_o | output | 4 | Selected endpoint index |
| frame_num_i | input | 11 | Current frame number from the engine |
| rx_pkt_done_i | input | 1 | Strobe: packet placed in the OUT FIFO |
| tx_pkt_done_i | input | 1 | Strobe: IN packet sent |
| stall_sent_i | input | 1 | Strobe: STALL handshake sent |
| setup_abort_i | input | 1 | Strobe: control transfer ended early |
| status_stage_done_i | input | 1 | Strobe: transfer completed |
| irq_en_i | input | 1 | Endpoint interrupt enable |
| stall_req_o | output | 1 | One-cycle request to stall the transaction |
| tx_ready_o | output | 1 | Packet ready for transmission |
| data_end_o | output | 1 | Current packet is the last of the transfer |
| fifo_flush_o | output | 1 | One-cycle FIFO flush request |
| ep0_irq_o | output | 1 | One-cycle endpoint interrupt pulse |

## Verification
The bench targets same-cycle collisions between firmware writes and engine strobes. If the clear wins, an acknowledgment written just as a new packet or abort arrives silently drops that event. The bench checks that a write of 1 to the stall-sent flag keeps it set while any write with that bit at 0 clears it; a plain read-modify-write model would get either case backwards. It also checks that the stall command and flush last exactly one cycle, and that the interrupt stays quiet when disabled. It rejects out-of-range index writes and writes aimed at the read-only frame bytes, either of which a careless decode would accept.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic [1:0] {
    ADDR_CSR    = 2'd0,
    ADDR_IDX    = 2'd1,
    ADDR_FRM_LO = 2'd2,
    ADDR_FRM_HI = 2'd3
  } reg_addr_e;

  // bit order is firmware-visible
  typedef struct packed {
    logic clr_abort;
    logic clr_rx;
    logic stall_cmd;
    logic abort;
    logic last_pkt;
    logic stall_done;
    logic tx_rdy;
    logic rx_rdy;
  } csr_t;
endpackage

// File: rtl/ctl_ep_status.sv
module ctl_ep_status
  import ctl_ep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csr_wr_i,
  input  csr_t wdata_i,
  input  logic rx_pkt_done_i,
  input  logic tx_pkt_done_i,
  input  logic stall_sent_i,
  input  logic setup_abort_i,
  input  logic status_stage_done_i,
  output csr_t csr_o
);
  logic stall_cmd_q, abort_q, last_q, stall_done_q, tx_rdy_q, rx_rdy_q;
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wdata_i.abort, wdata_i.rx_rdy};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_cmd_q  <= 1'b0;
      abort_q      <= 1'b0;
      last_q       <= 1'b0;
      stall_done_q <= 1'b0;
      tx_rdy_q     <= 1'b0;
      rx_rdy_q     <= 1'b0;
    end else begin
      stall_cmd_q <= csr_wr_i & wdata_i.stall_cmd;
      // engine set beats firmware clear
      if (setup_abort_i) abort_q <= 1'b1;
      else if (csr_wr_i && wdata_i.clr_abort) abort_q <= 1'b0;
      if (rx_pkt_done_i) rx_rdy_q <= 1'b1;
      else if (csr_wr_i && wdata_i.clr_rx) rx_rdy_q <= 1'b0;
      if (stall_sent_i) stall_done_q <= 1'b1;
      else if (csr_wr_i && !wdata_i.stall_done) stall_done_q <= 1'b0;
      // firmware set beats engine clear
      if (csr_wr_i && wdata_i.tx_rdy) tx_rdy_q <= 1'b1;
      else if (tx_pkt_done_i) tx_rdy_q <= 1'b0;
      if (csr_wr_i && wdata_i.last_pkt) last_q <= 1'b1;
      else if (status_stage_done_i) last_q <= 1'b0;
    end
  end

  always_comb begin
    csr_o            = '0;
    csr_o.stall_cmd  = stall_cmd_q;
    csr_o.abort      = abort_q;
    csr_o.last_pkt   = last_q;
    csr_o.stall_done = stall_done_q;
    csr_o.tx_rdy     = tx_rdy_q;
    csr_o.rx_rdy     = rx_rdy_q;
  end
endmodule

// File: rtl/ctl_ep_event.sv
module ctl_ep_event #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] ev_i,
  input  logic               irq_en_i,
  input  logic               flush_ev_i,
  output logic               irq_o,
  output logic               flush_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o   <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      irq_o   <= irq_en_i & (|ev_i);
      flush_o <= flush_ev_i;
    end
  end
endmodule

// File: rtl/ctl_ep_regs.sv
module ctl_ep_regs
  import ctl_ep_pkg::*;
#(
  parameter int NUM_EP  = 6,
  parameter int IDX_W   = 4,
  parameter int FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  input  csr_t               csr_i,
  input  logic [FRAME_W-1:0] frame_num_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [7:0]         rdata_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_EP - 1);

  logic [IDX_W-1:0] idx_q;
  logic [15:0]      frm_ext;
  logic             unused_wdata;
  assign unused_wdata = ^reg_wdata_i[7:IDX_W];
  assign frm_ext = 16'(frame_num_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (reg_wr_i && reg_addr_i == ADDR_IDX && reg_wdata_i[IDX_W-1:0] <= IDX_MAX)
      idx_q <= reg_wdata_i[IDX_W-1:0];
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      ADDR_CSR:    rdata_o = csr_i;
      ADDR_IDX:    rdata_o = 8'(idx_q);
      ADDR_FRM_LO: rdata_o = frm_ext[7:0];
      ADDR_FRM_HI: rdata_o = frm_ext[15:8];
      default:     rdata_o = '0;
    endcase
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/ctl_ep_csr.sv
module ctl_ep_csr
  import ctl_ep_pkg::*;
#(
  parameter int NUM_EP  = 6,
  parameter int IDX_W   = 4,
  parameter int FRAME_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic [IDX_W-1:0]   ep_index_o,
  input  logic [FRAME_W-1:0] frame_num_i,
  input  logic               rx_pkt_done_i,
  input  logic               tx_pkt_done_i,
  input  logic               stall_sent_i,
  input  logic               setup_abort_i,
  input  logic               status_stage_done_i,
  input  logic               irq_en_i,
  output logic               stall_req_o,
  output logic               tx_ready_o,
  output logic               data_end_o,
  output logic               fifo_flush_o,
  output logic               ep0_irq_o
);
  localparam int NUM_SRC = 4;

  csr_t csr_q;
  logic csr_wr;
  assign csr_wr = reg_wr_i && (reg_addr_i == ADDR_CSR);

  ctl_ep_status u_status (
    .clk_i               (clk_i),
    .rst_ni              (rst_ni),
    .csr_wr_i            (csr_wr),
    .wdata_i             (csr_t'(reg_wdata_i)),
    .rx_pkt_done_i       (rx_pkt_done_i),
    .tx_pkt_done_i       (tx_pkt_done_i),
    .stall_sent_i        (stall_sent_i),
    .setup_abort_i       (setup_abort_i),
    .status_stage_done_i (status_stage_done_i),
    .csr_o               (csr_q)
  );

  ctl_ep_event #(.NUM_SRC(NUM_SRC)) u_event (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       ({rx_pkt_done_i, tx_pkt_done_i, stall_sent_i, setup_abort_i}),
    .irq_en_i   (irq_en_i),
    .flush_ev_i (setup_abort_i),
    .irq_o      (ep0_irq_o),
    .flush_o    (fifo_flush_o)
  );

  ctl_ep_regs #(.NUM_EP(NUM_EP), .IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .csr_i       (csr_q),
    .frame_num_i (frame_num_i),
    .idx_o       (ep_index_o),
    .rdata_o     (reg_rdata_o)
  );

  assign stall_req_o = csr_q.stall_cmd;
  assign tx_ready_o  = csr_q.tx_rdy;
  assign data_end_o  = csr_q.last_pkt;
endmodule

// File: rtl/ctl_ep_csr_chk.sv
module ctl_ep_csr_chk
  import ctl_ep_pkg::*;
#(
  parameter int NUM_EP = 6,
  parameter int IDX_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [1:0]       reg_addr_i,
  input logic             rx_pkt_done_i,
  input logic             tx_pkt_done_i,
  input logic             stall_sent_i,
  input logic             setup_abort_i,
  input logic             irq_en_i,
  input logic             stall_req_o,
  input logic             tx_ready_o,
  input logic             fifo_flush_o,
  input logic             ep0_irq_o,
  input logic [IDX_W-1:0] ep_index_o,
  input csr_t             csr_q
);
  logic any_ev;
  assign any_ev = rx_pkt_done_i | tx_pkt_done_i | stall_sent_i | setup_abort_i;

  // R3
  abort_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_abort_i |=> (fifo_flush_o && csr_q.abort));
  // R3
  flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_flush_o && !setup_abort_i) |=> !fifo_flush_o);
  // R4
  stall_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_req_o && !reg_wr_i) |=> !stall_req_o);
  // R5
  stall_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csr_q.stall_done) |-> $past(reg_wr_i && reg_addr_i == ADDR_CSR));
  // R9
  rx_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pkt_done_i |=> csr_q.rx_rdy);
  // R9
  stall_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_sent_i |=> csr_q.stall_done);
  // R6
  tx_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ready_o) |-> $past(tx_pkt_done_i));
  // R10
  irq_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_en_i && any_ev) |=> ep0_irq_o);
  // R10
  irq_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_en_i && any_ev) |=> !ep0_irq_o);
  // R11
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ep_index_o) < NUM_EP);
endmodule

bind ctl_ep_csr ctl_ep_csr_chk #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .rx_pkt_done_i (rx_pkt_done_i),
  .tx_pkt_done_i (tx_pkt_done_i),
  .stall_sent_i  (stall_sent_i),
  .setup_abort_i (setup_abort_i),
  .irq_en_i      (irq_en_i),
  .stall_req_o   (stall_req_o),
  .tx_ready_o    (tx_ready_o),
  .fifo_flush_o  (fifo_flush_o),
  .ep0_irq_o     (ep0_irq_o),
  .ep_index_o    (ep_index_o),
  .csr_q         (csr_q)
);

// File: tb/sim_ctl_ep_csr.sv
module sim_ctl_ep_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [3:0]  idx;
  logic [10:0] frame = 11'h000;
  logic        rx = 0, tx = 0, st = 0, ab = 0, sd = 0, en = 0;
  logic        sreq, txr, dend, flush, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_ep_csr u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ep_index_o(idx),
    .frame_num_i(frame), .rx_pkt_done_i(rx), .tx_pkt_done_i(tx),
    .stall_sent_i(st), .setup_abort_i(ab), .status_stage_done_i(sd),
    .irq_en_i(en), .stall_req_o(sreq), .tx_ready_o(txr), .data_end_o(dend),
    .fifo_flush_o(flush), .ep0_irq_o(irq)
  );

  // {wr, addr, wdata, ev{rx,tx,st,ab,sd}, en, exp_rdata, exp_irq, exp_flush, exp_sreq}
  localparam int NV = 22;
  localparam logic [27:0] TBL [NV] = '{
    {1'b0, 2'd0, 8'h00, 5'b00000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R1
    {1'b1, 2'd0, 8'h02, 5'b00000, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0}, // R6
    {1'b0, 2'd0, 8'h00, 5'b01000, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0}, // R6
    {1'b0, 2'd0, 8'h00, 5'b10000, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0}, // R7
    {1'b1, 2'd0, 8'h40, 5'b00000, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R2
    {1'b0, 2'd0, 8'h00, 5'b00010, 1'b1, 8'h10, 1'b1, 1'b1, 1'b0}, // R3
    {1'b1, 2'd0, 8'h80, 5'b00000, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R2
    {1'b1, 2'd0, 8'h20, 5'b00000, 1'b1, 8'h20, 1'b0, 1'b0, 1'b1}, // R4
    {1'b0, 2'd0, 8'h00, 5'b00000, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    {1'b0, 2'd0, 8'h00, 5'b00100, 1'b1, 8'h04, 1'b1, 1'b0, 1'b0}, // R5
    {1'b1, 2'd0, 8'h04, 5'b00000, 1'b1, 8'h04, 1'b0, 1'b0, 1'b0}, // R5
    {1'b1, 2'd0, 8'h00, 5'b00000, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // R5
    {1'b1, 2'd0, 8'h0A, 5'b00000, 1'b1, 8'h0A, 1'b0, 1'b0, 1'b0}, // R8
    {1'b0, 2'd0, 8'h00, 5'b01000, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0}, // R10
    {1'b0, 2'd0, 8'h00, 5'b00001, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R8
    {1'b0, 2'd0, 8'h00, 5'b10000, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R7
    {1'b1, 2'd0, 8'h40, 5'b10000, 1'b1, 8'h01, 1'b1, 1'b0, 1'b0}, // R9
    {1'b1, 2'd0, 8'h40, 5'b00000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R2
    {1'b1, 2'd0, 8'h11, 5'b00000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R7
    {1'b1, 2'd1, 8'h05, 5'b00000, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0}, // R11
    {1'b1, 2'd1, 8'h06, 5'b00000, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0}, // R11
    {1'b1, 2'd1, 8'hF3, 5'b00000, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0}  // R11
  };

  function automatic string row_req(int r);
    case (r)
      0: return "R1";
      1, 2: return "R6";
      3, 15, 18: return "R7";
      4, 6, 17: return "R2";
      5: return "R3";
      7, 8: return "R4";
      9, 10, 11: return "R5";
      12, 14: return "R8";
      13: return "R10";
      16: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, return at the next negedge
  task automatic cyc(logic w, logic [1:0] a, logic [7:0] d, logic [4:0] ev, logic e);
    wr = w; addr = a; wdata = d; {rx, tx, st, ab, sd} = ev; en = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_rd(logic [1:0] a);
    cyc(1'b0, a, 8'h00, 5'b00000, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values while held in reset
    chk("R1", rdata, 8'h00);
    chk("R1", {3'b0, sreq, txr, dend, flush, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 2'd1;
    #0.5 chk("R1", rdata, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = TBL[i];
      cyc(v[27], v[26:25], v[24:17], v[16:12], v[11]);
      chk(row_req(i), rdata, v[10:3]);
      chk(row_req(i), {5'b0, irq, flush, sreq}, {5'b0, v[2:0]});
    end
    chk("R11", 8'(idx), 8'h03);

    // R12 frame readback, writes ignored
    frame = 11'h5A7;
    idle_rd(2'd2); chk("R12", rdata, 8'hA7);
    cyc(1'b1, 2'd3, 8'hFF, 5'b00000, 1'b0); chk("R12", rdata, 8'h05);
    cyc(1'b1, 2'd2, 8'h00, 5'b00000, 1'b0); chk("R12", rdata, 8'hA7);
    frame = 11'h7FF;
    idle_rd(2'd3); chk("R12", rdata, 8'h07);

    // R9 abort set beats clear command in the same cycle
    cyc(1'b1, 2'd0, 8'h80, 5'b00010, 1'b1);
    chk("R9", rdata, 8'h10);
    chk("R3", {7'b0, flush}, 8'h01);
    idle_rd(2'd0); chk("R3", {7'b0, flush}, 8'h00);
    cyc(1'b1, 2'd0, 8'h80, 5'b00000, 1'b0); chk("R2", rdata, 8'h00);

    // R9 stall-sent set beats write-0 clear
    cyc(1'b1, 2'd0, 8'h00, 5'b00100, 1'b0); chk("R9", rdata, 8'h04);
    idle_rd(2'd0); chk("R5", rdata, 8'h04);
    cyc(1'b0, 2'd0, 8'h00, 5'b11011, 1'b0); chk("R5", rdata & 8'h04, 8'h04);
    cyc(1'b1, 2'd0, 8'h40, 5'b00000, 1'b0); chk("R5", rdata, 8'h10);
    cyc(1'b1, 2'd0, 8'h80, 5'b00000, 1'b0); chk("R2", rdata, 8'h00);

    // R8 firmware set beats same-cycle status-stage clear
    cyc(1'b1, 2'd0, 8'h08, 5'b00001, 1'b0);
    chk("R8", rdata, 8'h08);
    chk("R8", {7'b0, dend}, 8'h01);
    cyc(1'b0, 2'd0, 8'h00, 5'b00001, 1'b0); chk("R8", {7'b0, dend}, 8'h00);

    // R6 write 0 to bit 1 ignored; tx_ready_o follows flag
    cyc(1'b1, 2'd0, 8'h02, 5'b00000, 1'b0); chk("R6", {7'b0, txr}, 8'h01);
    cyc(1'b1, 2'd0, 8'h04, 5'b00000, 1'b0); chk("R6", rdata, 8'h02);
    cyc(1'b0, 2'd0, 8'h00, 5'b01000, 1'b0); chk("R6", {7'b0, txr}, 8'h00);

    // R10 several events in one cycle: one pulse
    cyc(1'b0, 2'd0, 8'h00, 5'b11110, 1'b1); chk("R10", {7'b0, irq}, 8'h01);
    cyc(1'b0, 2'd0, 8'h00, 5'b00000, 1'b1); chk("R10", {7'b0, irq}, 8'h00);

    // R1 reset mid-run clears everything
    cyc(1'b1, 2'd0, 8'h2A, 5'b00000, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R1", rdata, 8'h00);
    chk("R1", 8'(idx), 8'h00);
    chk("R1", {3'b0, sreq, txr, dend, flush, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    idle_rd(2'd0); chk("R1", rdata, 8'h00);

    finish_run();
  end
endmodule